// File: doc/BRIEF.md
# Stereo Digital Volume with Mute and Channel Mode

This block is the gain stage for a stereo stream of 24-bit signed audio samples. Each accepted left/right pair first goes through a channel-mode selector. The selector either passes the pair straight through, copies one side to both outputs, or replaces both with their halved sum. After the selector, an optional polarity inversion is applied. Each channel then gets its own logarithmic attenuation, which can be set in 256 steps of 0.375 dB. A mute control forces both outputs to silence at once.

The attenuation settings are targets, not the gain in use. Each channel keeps a working code. That code moves one step toward its target for every sample pair that is accepted, so a gain change becomes a short staircase and never a jump. Muting skips this ramp: the working code is loaded with the target at once. The linear gain comes from a table that is computed while the design is elaborated.

Samples enter and leave over valid/ready streams, with one output register between them. A pair that is accepted on one clock edge appears on the output from that edge on. The input is ready whenever the output register is empty or is being drained in the same cycle. When the output is held off, the output register keeps its pair and stops taking new input until the output is drained. The control pins are plain levels. They are sampled on the edge that accepts a sample.

Top module: `stereo_vol`

## Requirements
- R1: A pair is accepted on a rising edge where in_valid and in_ready are both 1, and its result is on out_left/out_right with out_valid high after that same edge. in_ready is 1 when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, the output pair and out_valid hold unchanged. out_valid drops after an edge with out_ready high and no new acceptance.
- R2: Working code c selects the gain word G(c) = round(65536 · 10^(−0.375·c/20)), which has 16 fractional bits. Code 0 is exactly unity (65536), and code 255 corresponds to −95.625 dB.
- R3: A channel output equals floor((x·G + 32768) / 65536), saturated to the range −8388608 to 8388607. Here x is the sample after mode selection and inversion.
- R4: When invert is 1, each selected sample is negated before the gain is applied. Input −8388608 inverted at code 0 gives 8388607.
- R5: chan_mode 00 passes left to out_left and right to out_right.
- R6: chan_mode 01 feeds the left input to both channels, and chan_mode 10 feeds the right input to both channels.
- R7: chan_mode 11 feeds floor((left + right) / 2) to both channels.
- R8: After reset, both working codes are 0. An accepted pair with mute low is scaled by the current working codes, and each code then moves one step toward its attenuation target, or stays put if it already equals the target.
- R9: An accepted pair with mute high produces 0 on both outputs, and each working code is loaded directly with its target.
- R10: A working code does not change in cycles without an accepted pair, whatever the attenuation inputs do.
- R11: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair is valid |
| in_ready | output | 1 | Block can take an input pair |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Downstream takes the output pair |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |
| atten_left | input | 8 | Left attenuation target, 0.375 dB per code |
| atten_right | input | 8 | Right attenuation target, 0.375 dB per code |
| invert | input | 1 | Negate both channels |
| mute | input | 1 | Silence output and load working codes with targets |
| chan_mode | input | 2 | 00 stereo, 01 left to both, 10 right to both, 11 halved sum |

## Verification
The working gain codes are hidden, and the ramp means that a given code is normally reached only after many samples. This makes it hard to check the whole gain table from the ports. The stimulus uses mute as a loader instead. A muted pair jumps each working code straight to any target, and the next unmuted pair then shows that code's gain. This allows a sweep of all 256 codes with two pairs per code. Idle-cycle code stability is checked by changing the targets with no traffic and then looking at the scaling of the next pair.

// File: rtl/vol_pkg.sv
package vol_pkg;

  localparam real STEP_DB = 0.375;

  typedef enum logic [1:0] {
    MODE_STEREO = 2'b00,
    MODE_LEFT   = 2'b01,
    MODE_RIGHT  = 2'b10,
    MODE_AVG    = 2'b11
  } chan_mode_e;

  // Linear gain for an attenuation code, as an unsigned fixed-point word
  // carrying frac fractional bits, rounded to nearest.
  function automatic int gain_word(input int code, input int frac);
    real att_db;
    real lin;
    att_db = STEP_DB * code;
    lin    = 10.0 ** (-att_db / 20.0);
    return $rtoi(lin * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom #(
  parameter int CODE_W = 8,
  parameter int FRAC_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [FRAC_W:0]   gain_o
);
  localparam int DEPTH = 1 << CODE_W;

  logic [FRAC_W:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [FRAC_W:0] WORD = (FRAC_W+1)'(vol_pkg::gain_word(i, FRAC_W));
    assign tbl[i] = WORD;
  end

  assign gain_o = tbl[code_i];

endmodule

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              mute_i,
  input  logic [CODE_W-1:0] target_i,
  output logic [CODE_W-1:0] cur_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o <= '0;
    end else if (step_en) begin
      if (mute_i)                cur_o <= target_i;
      else if (cur_o < target_i) cur_o <= cur_o + 1'b1;
      else if (cur_o > target_i) cur_o <= cur_o - 1'b1;
    end
  end

  // R8: an unmuted sample moves the working code by at most one step
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !mute_i) |=>
      (({1'b0, cur_o}) == ({1'b0, $past(cur_o)})) ||
      (({1'b0, cur_o}) == ({1'b0, $past(cur_o)} + 1'b1)) ||
      (({1'b0, cur_o} + 1'b1) == ({1'b0, $past(cur_o)})));

  // R9: a muted sample loads the target directly
  a_r9_mute_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mute_i) |=> (cur_o == $past(target_i)));

  // R10: no accepted sample, no movement
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cur_o));

endmodule

// File: rtl/vol_chan_dp.sv
module vol_chan_dp #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 16
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic                     inv_i,
  input  logic                     mute_i,
  input  logic [FRAC_W:0]          gain_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int XW = DATA_W + 1;
  localparam int PW = XW + FRAC_W + 2;
  localparam logic signed [PW-1:0] HALF =
    {{(PW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [PW-1:0] MAXV =
    {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV =
    {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [XW-1:0] xe;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;

  always_comb begin
    xe = {x_i[DATA_W-1], x_i};
    if (inv_i) xe = -xe;
    prod = $signed(xe) * $signed({1'b0, gain_i});
    rnd  = (prod + HALF) >>> FRAC_W;
    if (mute_i)           y_o = '0;
    else if (rnd > MAXV)  y_o = MAXV[DATA_W-1:0];
    else if (rnd < MINV)  y_o = MINV[DATA_W-1:0];
    else                  y_o = rnd[DATA_W-1:0];
  end

endmodule

// File: rtl/stereo_vol.sv
module stereo_vol #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  input  logic [CODE_W-1:0] atten_left,
  input  logic [CODE_W-1:0] atten_right,
  input  logic              invert,
  input  logic              mute,
  input  logic [1:0]        chan_mode
);
  import vol_pkg::*;

  localparam int NCH = 2;

  logic                     acc;
  logic signed [DATA_W:0]   sum_lr;
  logic [DATA_W-1:0]        src    [NCH];
  logic [CODE_W-1:0]        target [NCH];
  logic [CODE_W-1:0]        code   [NCH];
  logic [FRAC_W:0]          gain   [NCH];
  logic signed [DATA_W-1:0] y      [NCH];
  chan_mode_e               mode;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign mode     = chan_mode_e'(chan_mode);

  assign target[0] = atten_left;
  assign target[1] = atten_right;

  assign sum_lr = $signed({in_left[DATA_W-1], in_left}) +
                  $signed({in_right[DATA_W-1], in_right});

  always_comb begin
    unique case (mode)
      MODE_LEFT:  begin src[0] = in_left;  src[1] = in_left;  end
      MODE_RIGHT: begin src[0] = in_right; src[1] = in_right; end
      MODE_AVG: begin
        src[0] = DATA_W'(sum_lr >>> 1);
        src[1] = DATA_W'(sum_lr >>> 1);
      end
      default:    begin src[0] = in_left;  src[1] = in_right; end
    endcase
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vol_ramp #(.CODE_W(CODE_W)) ramp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (acc),
      .mute_i   (mute),
      .target_i (target[ch]),
      .cur_o    (code[ch])
    );

    vol_gain_rom #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) rom_i (
      .code_i (code[ch]),
      .gain_o (gain[ch])
    );

    vol_chan_dp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) dp_i (
      .x_i    ($signed(src[ch])),
      .inv_i  (invert),
      .mute_i (mute),
      .gain_i (gain[ch]),
      .y_o    (y[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_left  <= y[0];
      out_right <= y[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: a stalled output pair holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));

  // R1: an accepted pair always shows up as valid output
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9: a muted pair comes out as silence
  a_r9_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mute) |=> (out_left == '0 && out_right == '0));

endmodule

// File: tb/stereo_vol_tb_top.sv
module stereo_vol_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;
  logic [7:0]  atten_left = '0;
  logic [7:0]  atten_right = '0;
  logic        invert = 1'b0;
  logic        mute = 1'b0;
  logic [1:0]  chan_mode = 2'b00;

  int n_chk = 0;
  int n_fail = 0;
  int mdl_l = 0;
  int mdl_r = 0;

  always #10 clk = ~clk;

  stereo_vol dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right),
    .atten_left(atten_left), .atten_right(atten_right),
    .invert(invert), .mute(mute), .chan_mode(chan_mode)
  );

  function automatic longint gw(input int c);
    real v;
    v = 10.0 ** (-(0.375 * c) / 20.0);
    return longint'($rtoi(v * 65536.0 + 0.5));
  endfunction

  function automatic int scale(input longint x, input int c, input bit inv, input bit mt);
    longint xe, p, y;
    if (mt) return 0;
    xe = inv ? -x : x;
    p  = xe * gw(c);
    y  = (p + 32768) >>> 16;
    if (y > 8388607)  y = 8388607;
    if (y < -8388608) y = -8388608;
    return int'(y);
  endfunction

  function automatic void pick(input int l, input int r, input int md,
                               output longint sl, output longint sr);
    case (md)
      1: begin sl = l; sr = l; end
      2: begin sl = r; sr = r; end
      3: begin sl = (longint'(l) + longint'(r)) >>> 1; sr = sl; end
      default: begin sl = l; sr = r; end
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_code(input int cur, input int tgt, input bit mt);
    if (mt) return tgt;
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  // Drive one pair with out_ready high, check the result, advance the model.
  task automatic push(input int l, input int r, input string tag);
    longint sl, sr;
    int el, er;
    pick(l, r, int'(chan_mode), sl, sr);
    el = scale(sl, mdl_l, invert, mute);
    er = scale(sr, mdl_r, invert, mute);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = l[23:0];
    in_right = r[23:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R1 out_valid"}, int'(out_valid), 1);
    chk(int'($signed(out_left)) == el, {tag, " left"}, int'($signed(out_left)), el);
    chk(int'($signed(out_right)) == er, {tag, " right"}, int'($signed(out_right)), er);
    mdl_l = next_code(mdl_l, int'(atten_left), mute);
    mdl_r = next_code(mdl_r, int'(atten_right), mute);
  endtask

  // Load both working codes through a muted pair.
  task automatic load_codes(input int cl, input int cr);
    atten_left  = cl[7:0];
    atten_right = cr[7:0];
    mute = 1'b1;
    push(12345, -54321, "R9 mute load");
    mute = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint sl, sr;
    int ea, eb, xa, xb, ta, tb;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);

    // R8: first pair after reset is at unity gain
    atten_left = 8'd0; atten_right = 8'd0;
    push(8388607, -8388608, "R8 reset code unity");

    // R2/R3: sweep every code, loaded through mute
    for (int c = 0; c < 256; c++) begin
      load_codes(c, 255 - c);
      case (c % 4)
        0: push(8388607, -8388608, "R2 R3 sweep");
        1: push(-1, 1, "R2 R3 sweep");
        2: push(c * 30011 - 4000000, 777777 - c * 17, "R2 R3 sweep");
        default: push(-8388607, 4194304, "R2 R3 sweep");
      endcase
    end

    // R4: inversion, including saturation
    load_codes(0, 40);
    invert = 1'b1;
    push(-8388608, 1000, "R4 invert");
    push(8388607, -8388608, "R4 invert");
    invert = 1'b0;

    // R5/R6/R7: every mode with distinct pairs
    for (int md = 0; md < 4; md++) begin
      chan_mode = md[1:0];
      load_codes(0, 20);
      push(1000, -3000, "R5 R6 R7 mode");
      push(8388607, 8388607, "R5 R6 R7 mode");
      push(-8388608, -8388607, "R5 R6 R7 mode");
      push(3, -6, "R5 R6 R7 mode");
      invert = 1'b1;
      push(-8388608, -8388608, "R4 R7 mode invert");
      invert = 1'b0;
    end
    chan_mode = 2'b00;

    // R8: ramp up on the left, down on the right
    load_codes(0, 10);
    atten_left = 8'd5; atten_right = 8'd7;
    for (int k = 0; k < 7; k++) push(4194304, 4194304, "R8 ramp");
    chk(mdl_l == 5 && mdl_r == 7, "R8 model settled", mdl_l, 5);

    // R10: target change with no traffic leaves the working code alone
    atten_left = 8'd200; atten_right = 8'd0;
    repeat (12) @(negedge clk);
    push(8388607, 8388607, "R10 idle stable");
    chk(mdl_l == 6 && mdl_r == 6, "R10 model", mdl_l, 6);

    // R1: back-pressure
    load_codes(30, 60);
    xa = 2000000; xb = -3000000;
    ta = scale(xa, 30, 1'b0, 1'b0);
    tb = scale(xb, 30, 1'b0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_left = xa[23:0]; in_right = xa[23:0];
    @(negedge clk);
    in_left = xb[23:0]; in_right = xb[23:0];
    chk(int'($signed(out_left)) == ta, "R1 first pair out", int'($signed(out_left)), ta);
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R1 stalled in_ready", int'(in_ready), 0);
      chk(out_valid == 1'b1 && int'($signed(out_left)) == ta, "R1 hold",
          int'($signed(out_left)), ta);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(int'($signed(out_left)) == tb, "R1 second pair out", int'($signed(out_left)), tb);
    chk(out_valid == 1'b1, "R1 second valid", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 drained", int'(out_valid), 0);

    // R7 spot check computed directly
    chan_mode = 2'b11;
    load_codes(0, 0);
    pick(5, 8, 3, sl, sr);
    ea = int'(sl); eb = 6;
    chk(ea == eb, "R7 floor average model", ea, eb);
    push(5, 8, "R7 average");
    chan_mode = 2'b00;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule